// File: doc/BRIEF.md
# Byte-Lane Write Control Memory

This block is a small synchronous single-port memory organised as four byte lanes of nine bits each, giving a 36-bit word. On every clock edge a set of active-low controls decides what happens: a global write that stores the whole word, a masked write of any subset of lanes selected by a master byte-write enable and four per-lane enables, or a read. A read returns the full word, whatever lane enables are presented.

The read path ends in a registered output with a drive-enable flag that stands in for a tri-state pad. The flag is raised for the cycle after a read and lowered after any form of write, so the data pins are never driven while the memory is being written. A sleep input puts the block into standby: neither read nor write happens, the stored words are kept, and the output stays undriven.

Top module: `bytewr_sram`

## Requirements
- R1: When `gw_n` is low (and `sleep` is low), all four lanes at `addr` are written from `wdata`, whatever `bwe_n` and `lane_n` are.
- R2: When `gw_n` and `bwe_n` are both high, the cycle is a read and no lane is written, whatever `lane_n` is.
- R3: When `gw_n` is high and `bwe_n` is low, each lane i whose `lane_n[i]` is low is written; lane i is bits 9*i+8 down to 9*i of the word. Lanes not selected keep their old contents. Any combination of lanes is accepted.
- R4: When `gw_n` is high, `bwe_n` is low and all four `lane_n` bits are high, the cycle is a read.
- R5: After the clock edge of a read cycle, `drive_en` is 1 and `rdata` holds the full 36-bit word stored at `addr` before that edge, independent of `lane_n`.
- R6: After the clock edge of any write cycle, `drive_en` is 0 and `rdata` is all zeros.
- R7: While `sleep` is high at a clock edge, no read or write takes place, stored contents are kept, and after that edge `drive_en` is 0 and `rdata` is zero.
- R8: After a synchronous reset, `drive_en` is 0 and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Standby request, active high |
| addr | input | 4 | Word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write master enable, active low |
| lane_n | input | 4 | Per-lane write enables, active low |
| rdata | output | 36 | Read data, zero when not driven |
| drive_en | output | 1 | Output drive enable |

## Verification
The assertions watch the control decode and the output flag on every cycle: a low global write always selects every lane, a cycle with the master enable high never writes, sleep blocks all lane writes and leaves the output undriven, and every write or read form is followed by the matching flag state. What only the bench scenarios can show is the data itself: that a masked write alters exactly the chosen lanes and leaves the others intact, that a read returns the word present before its edge, and that contents survive standby.

// File: rtl/bytewr_pkg.sv
package bytewr_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [LANES-1:0] mask;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic sleep, input logic gw_n,
                                        input logic bwe_n, input logic [LANES-1:0] lane_n);
        cmd_t c;
        c.op   = OP_IDLE;
        c.mask = '0;
        if (!sleep) begin
            if (!gw_n)
                c.mask = '1;
            else if (!bwe_n)
                c.mask = ~lane_n;
            c.op = (c.mask != '0) ? OP_WRITE : OP_READ;
        end
        return c;
    endfunction
endpackage

// File: rtl/bytewr_decode.sv
module bytewr_decode
    import bytewr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_n,
    output cmd_t             cmd
);
    always_comb cmd = decode_cmd(sleep, gw_n, bwe_n, lane_n);

    // R1
    gw_all_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (!gw_n && !sleep) |-> (cmd.mask == '1));

    // R2
    read_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (gw_n && bwe_n) |-> (cmd.mask == '0));

    // R7
    sleep_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |-> (cmd.mask == '0));
endmodule

// File: rtl/bytewr_array.sv
module bytewr_array
    import bytewr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_q,
    output logic              drive_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] rd_word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (cmd.op == OP_WRITE && cmd.mask[g])
                store[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rd_word[g*LANE_W +: LANE_W] = store[addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= '0;
            drive_q <= 1'b0;
        end else if (cmd.op == OP_READ) begin
            rd_q    <= rd_word;
            drive_q <= 1'b1;
        end else begin
            drive_q <= 1'b0;
        end
    end

    // R6
    write_undriven_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_WRITE) |=> !drive_q);
endmodule

// File: rtl/bytewr_sram.sv
module bytewr_sram
    import bytewr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  lane_n,
    output logic [WORD_W-1:0] rdata,
    output logic              drive_en
);
    cmd_t              cmd;
    logic [WORD_W-1:0] rd_q;
    logic              drive_q;

    bytewr_decode i_decode (
        .clk    (clk),
        .rst    (rst),
        .sleep  (sleep),
        .gw_n   (gw_n),
        .bwe_n  (bwe_n),
        .lane_n (lane_n),
        .cmd    (cmd)
    );

    bytewr_array #(.ADDR_W(ADDR_W)) i_array (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .addr    (addr),
        .wdata   (wdata),
        .rd_q    (rd_q),
        .drive_q (drive_q)
    );

    assign drive_en = drive_q;
    assign rdata    = drive_q ? rd_q : '0;

    // R7
    sleep_undriven_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !drive_en);

    // R5 and R4
    read_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep && gw_n && (bwe_n || (&lane_n))) |=> drive_en);
endmodule

// File: tb/test_bytewr_sram.sv
module test_bytewr_sram;
    localparam int AW = 4;
    localparam int W  = 36;

    logic          clk = 1'b0;
    logic          rst;
    logic          sleep;
    logic [AW-1:0] addr;
    logic [W-1:0]  wdata;
    logic          gw_n;
    logic          bwe_n;
    logic [3:0]    lane_n;
    logic [W-1:0]  rdata;
    logic          drive_en;

    logic [W-1:0]  ref_mem [16];
    int            n_tests = 0;
    int            n_fail  = 0;

    always #5 clk = ~clk;

    bytewr_sram #(.ADDR_W(AW)) i_bytewr_sram (
        .clk(clk), .rst(rst), .sleep(sleep), .addr(addr), .wdata(wdata),
        .gw_n(gw_n), .bwe_n(bwe_n), .lane_n(lane_n),
        .rdata(rdata), .drive_en(drive_en)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic cycle(input logic s, input logic g, input logic b, input logic [3:0] l,
                         input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        sleep = s; gw_n = g; bwe_n = b; lane_n = l; addr = a; wdata = d;
        @(negedge clk);
    endtask

    task automatic read_and_check(input string req, input logic [AW-1:0] a, input logic [3:0] l);
        cycle(1'b0, 1'b1, 1'b1, l, a, {W{1'b1}});
        check(req, {35'd0, drive_en}, 36'd1);
        check(req, rdata, ref_mem[a]);
    endtask

    function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] d,
                                           input logic [3:0] sel);
        logic [W-1:0] r = old;
        for (int i = 0; i < 4; i++)
            if (sel[i]) r[i*9 +: 9] = d[i*9 +: 9];
        return r;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; sleep = 1'b0; gw_n = 1'b1; bwe_n = 1'b1; lane_n = 4'hF;
        addr = '0; wdata = '0;
        @(negedge clk); @(negedge clk);
        check("R8 drive_en", {35'd0, drive_en}, 36'd0);
        check("R8 rdata", rdata, 36'd0);
        rst = 1'b0;
    endtask

    task automatic t_global_write();
        for (int a = 0; a < 16; a++) begin
            logic [W-1:0] d = {4'(a), 32'hA5C3_0000 + 32'(a * 977)};
            // lane enables and master enable set to odd values: gw_n must override
            cycle(1'b0, 1'b0, 1'b1, 4'(a), 4'(a), d);
            ref_mem[a] = d;
            if (a == 3) begin
                check("R6 drive_en after global write", {35'd0, drive_en}, 36'd0);
                check("R6 rdata after global write", rdata, 36'd0);
            end
        end
        read_and_check("R1 global write", 4'd3, 4'h0);
        read_and_check("R1 global write", 4'd12, 4'hA);
    endtask

    task automatic t_master_high_read();
        cycle(1'b0, 1'b1, 1'b1, 4'h0, 4'd5, 36'h0_0000_0000);
        check("R2 read flag", {35'd0, drive_en}, 36'd1);
        check("R2 read data", rdata, ref_mem[5]);
        read_and_check("R2 no write", 4'd5, 4'h5);
    endtask

    task automatic t_lane_masks();
        for (int m = 1; m < 16; m++) begin
            logic [AW-1:0] a = 4'(m);
            logic [W-1:0]  d = {W{1'b0}} | (36'h1_2345_6789 * 36'(m + 3));
            cycle(1'b0, 1'b1, 1'b0, ~4'(m), a, d);
            check("R6 drive_en after lane write", {35'd0, drive_en}, 36'd0);
            ref_mem[a] = merge(ref_mem[a], d, 4'(m));
            read_and_check("R3 lane write", a, 4'h0);
        end
    endtask

    task automatic t_no_lane_read();
        cycle(1'b0, 1'b1, 1'b0, 4'hF, 4'd7, 36'hF_FFFF_FFFF);
        check("R4 read flag", {35'd0, drive_en}, 36'd1);
        check("R4 read data", rdata, ref_mem[7]);
        read_and_check("R4 no write", 4'd7, 4'h3);
    endtask

    task automatic t_back_to_back();
        logic [W-1:0] d = 36'h9_8765_4321;
        read_and_check("R5 read before write", 4'd9, 4'h0);
        cycle(1'b0, 1'b0, 1'b0, 4'h0, 4'd9, d);
        check("R6 undriven", {35'd0, drive_en}, 36'd0);
        ref_mem[9] = d;
        read_and_check("R5 read after write", 4'd9, 4'h0);
    endtask

    task automatic t_sleep();
        read_and_check("R5 before sleep", 4'd2, 4'h0);
        cycle(1'b1, 1'b0, 1'b0, 4'h0, 4'd2, 36'h0_DEAD_BEEF);
        check("R7 sleep write undriven", {35'd0, drive_en}, 36'd0);
        check("R7 sleep rdata", rdata, 36'd0);
        cycle(1'b1, 1'b1, 1'b1, 4'hF, 4'd2, 36'd0);
        check("R7 sleep read undriven", {35'd0, drive_en}, 36'd0);
        read_and_check("R7 contents kept", 4'd2, 4'h0);
    endtask

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_global_write();
        t_master_high_read();
        t_lane_masks();
        t_no_lane_read();
        t_back_to_back();
        t_sleep();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule